// File: doc/BRIEF.md
# Two-Wire Word Register Slave

This block is the target side of a two-wire serial bus (open-drain clock and data, I2C-style signalling). It gives a bus host read and write access to a small internal file of 16-bit registers. The host selects a register with a 16-bit register address and then moves whole words, each as two bytes with the upper byte first. SCL and SDA are sampled with the system clock, so the bus must run well below the system clock rate.

An internal word pointer survives from one transaction to the next. A write loads the pointer from the address phase and then stores consecutive words. A read either follows a fresh address phase and a repeated START (random location) or starts with a read-direction device address at once (current location), which continues from wherever the pointer stands. The pointer steps by one after each complete word and wraps at the end of the implemented range.

Top module: `tw_word_slave`

## Requirements
- R1: The slave acknowledges a device address only when its upper seven bits equal the parameter DEV_ADDR. Bit 0 is the direction (0 write, 1 read). On a mismatch the slave leaves SDA released until the next START.
- R2: After a matching write-direction address, the next two bytes form the register address, upper byte first. The slave acknowledges both of them and every later write data byte.
- R3: Each further pair of write bytes (upper byte, then lower byte) is stored as one word at the pointer, and the pointer then advances by one.
- R4: A repeated START with a read-direction address that follows an address phase returns data starting at the register just addressed.
- R5: A read-direction address given directly after a START, with no address phase, returns data from the current pointer.
- R6: Read data is sent as the upper byte then the lower byte of each word, most significant bit first. While the host acknowledges, consecutive words follow, and the pointer advances once per completed word.
- R7: A not-acknowledge from the host after a read byte ends the read: the slave releases SDA and waits for STOP or START.
- R8: A write that stops after only the upper data byte changes no register.
- R9: The pointer keeps only the low log2(DEPTH) bits of the register address (DEPTH is a power of two) and wraps from DEPTH-1 to 0.
- R10: A START seen in the middle of a byte abandons that byte and returns to the device-address phase without changing the pointer.
- R11: SDA is driven open-drain through sda_oe_o (1 pulls the line low), and sda_oe_o changes only while SCL is low.
- R12: After reset every register and the pointer are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, used to sample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The bench drives directed transfers that separate the addressing modes: a write followed by a random read, a current-location read that has to land on the pointer left by the previous transfer, and sequential reads whose last word crosses the top of the register range. Each of these fails in a different way if the pointer is reloaded, advanced per byte rather than per word, or not wrapped. Further cases cover a foreign device address, a write cut short after one data byte, and a START placed three bits into a byte; each of them must leave registers and pointer as the model predicts. Seeded random write and read bursts with random addresses, including aliased ones above the range, then compare every word with the bench model.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WHI, ST_WLO, ST_RD, ST_SKIP
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // idle bus is high: reset to 1 so no false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tw_word_slave.sv
module tw_word_slave
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         DEPTH       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_w), .stop_o(stop_w)
  );

  tw_state_e     state_q;
  logic [3:0]    cnt_q;      // SCL rises seen in this byte frame, 0..9
  logic [7:0]    shreg_q, tx_q, addr_hi_q, data_hi_q;
  logic          dir_q, nack_q, rd_lo_q, oe_q;
  logic [AW-1:0] ptr_q, ptr_inc, raddr;
  logic [15:0]   rdata;
  logic          wen;
  logic [2:0]    bit_idx;
  logic          active;

  assign ptr_inc = ptr_q + AW'(1);
  assign raddr   = (state_q == ST_RD && rd_lo_q) ? ptr_inc : ptr_q;
  assign wen     = scl_fall && cnt_q == 4'd8 && state_q == ST_WLO;
  assign bit_idx = 3'(4'd7 - cnt_q);
  assign active  = state_q != ST_IDLE && state_q != ST_SKIP;

  tw_regfile #(.DEPTH(DEPTH), .DW(16)) u_rf (
    .clk_i, .rst_ni,
    .we_i(wen), .waddr_i(ptr_q), .wdata_i({data_hi_q, shreg_q}),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      addr_hi_q <= '0;
      data_hi_q <= '0;
      dir_q     <= 1'b0;
      nack_q    <= 1'b0;
      rd_lo_q   <= 1'b0;
      oe_q      <= 1'b0;
      ptr_q     <= '0;
    end else if (start_w) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      rd_lo_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_w) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (active && scl_rise) begin
      if (cnt_q < 4'd8)  shreg_q <= {shreg_q[6:0], sda_s};
      if (cnt_q == 4'd8) nack_q  <= sda_s;
      if (cnt_q < 4'd9)  cnt_q   <= cnt_q + 4'd1;
    end else if (active && scl_fall) begin
      if (cnt_q == 4'd8) begin
        // byte complete: set up the acknowledge slot
        unique case (state_q)
          ST_DEV: begin
            if (shreg_q[7:1] == DEV_ADDR) begin
              oe_q  <= 1'b1;
              dir_q <= shreg_q[0];
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_AHI: begin addr_hi_q <= shreg_q; oe_q <= 1'b1; end
          ST_ALO: begin ptr_q <= AW'({addr_hi_q, shreg_q}); oe_q <= 1'b1; end
          ST_WHI: begin data_hi_q <= shreg_q; oe_q <= 1'b1; end
          ST_WLO: begin ptr_q <= ptr_inc; oe_q <= 1'b1; end
          ST_RD:  oe_q <= 1'b0;
          default: ;
        endcase
      end else if (cnt_q == 4'd9) begin
        // acknowledge slot over
        cnt_q <= '0;
        oe_q  <= 1'b0;
        unique case (state_q)
          ST_DEV: begin
            if (dir_q) begin
              state_q <= ST_RD;
              tx_q    <= rdata[15:8];
              rd_lo_q <= 1'b0;
              oe_q    <= ~rdata[15];
            end else begin
              state_q <= ST_AHI;
            end
          end
          ST_AHI: state_q <= ST_ALO;
          ST_ALO: state_q <= ST_WHI;
          ST_WHI: state_q <= ST_WLO;
          ST_WLO: state_q <= ST_WHI;
          ST_RD: begin
            if (rd_lo_q) ptr_q <= ptr_inc;
            if (nack_q) begin
              state_q <= ST_SKIP;
            end else if (rd_lo_q) begin
              tx_q    <= rdata[15:8];
              oe_q    <= ~rdata[15];
              rd_lo_q <= 1'b0;
            end else begin
              tx_q    <= rdata[7:0];
              oe_q    <= ~rdata[7];
              rd_lo_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (cnt_q != 4'd0 && state_q == ST_RD) begin
        oe_q <= ~tx_q[bit_idx];
      end
    end
  end

  assign sda_oe_o = oe_q;

  assert_oe_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  assert_skip_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_o);

  assert_ack_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && cnt_q == 4'd9 &&
     (state_q == ST_DEV || state_q == ST_AHI || state_q == ST_ALO ||
      state_q == ST_WHI || state_q == ST_WLO)) |-> sda_oe_o);

  assert_start_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (state_q == ST_DEV && cnt_q == 4'd0));

  assert_ptr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) != ST_ALO && ptr_q != $past(ptr_q)) |->
      ptr_q == $past(ptr_q) + AW'(1));
endmodule

// File: tb/tw_word_slave_tb_top.sv
module tw_word_slave_tb_top;
  localparam int         DEPTH = 16;
  localparam logic [6:0] DEV   = 7'h48;
  localparam int         W     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  logic [15:0] exp_mem [DEPTH];
  int exp_ptr = 0;

  always #10 clk = ~clk;

  tw_word_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe)
  );

  // R11 monitor: output enable may move only while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && m_scl) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (W) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw();
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0; hw();
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); b = sda_line; m_scl = 1'b0; hw();
  endtask

  task automatic tx_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic rx_byte(output logic [7:0] v, input bit ack_it);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack_it);
  endtask

  function automatic int wrap(input int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic addr_phase(input logic [15:0] a);
    bit ack;
    bus_start();
    tx_byte({DEV, 1'b0}, ack); chk(ack, "R1 dev ack", ack, 1);
    tx_byte(a[15:8], ack);     chk(ack, "R2 addr hi ack", ack, 1);
    tx_byte(a[7:0], ack);      chk(ack, "R2 addr lo ack", ack, 1);
    exp_ptr = a % DEPTH;
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    bit ack_h, ack_l;
    logic [15:0] d;
    addr_phase(a);
    for (int i = 0; i < n; i++) begin
      d = 16'($urandom);
      tx_byte(d[15:8], ack_h);
      tx_byte(d[7:0], ack_l);
      chk(ack_h && ack_l, "R2 data ack", {ack_h, ack_l}, 3);
      exp_mem[exp_ptr] = d;
      exp_ptr = wrap(exp_ptr);
    end
    bus_stop();
  endtask

  // random=1: address phase + repeated START; random=0: current location
  task automatic do_read(input bit random, input logic [15:0] a, input int n,
                         input string tag);
    bit ack;
    logic [7:0] hi, lo;
    if (random) begin
      addr_phase(a);
      bus_start();
    end else begin
      bus_start();
    end
    tx_byte({DEV, 1'b1}, ack);
    chk(ack, "R1 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rx_byte(hi, 1'b1);
      rx_byte(lo, i != n - 1);
      chk({hi, lo} == exp_mem[exp_ptr], tag, {hi, lo}, exp_mem[exp_ptr]);
      exp_ptr = wrap(exp_ptr);
    end
    hw();
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    do_read(1'b0, 16'h0, 1, "R12 reg0 after reset");

    // R3, R4: write then random read
    do_write(16'h0005, 2);
    do_read(1'b1, 16'h0005, 2, "R4 random read");

    // R5: current location continues at pointer (now 7)
    do_write(16'h0008, 1);
    do_read(1'b1, 16'h0006, 1, "R4 random read single");
    do_read(1'b0, 16'h0, 2, "R5 current read");

    // R6: longer sequential read
    do_write(16'h0000, 4);
    do_read(1'b1, 16'h0000, 4, "R6 sequential read");

    // R9: wrap at top of range and aliased address
    do_write(16'(DEPTH - 1), 2);
    do_read(1'b1, 16'(DEPTH - 1), 2, "R9 wrap read");
    do_write(16'h0013, 1);
    do_read(1'b1, 16'h0003, 1, "R9 alias high bits");

    // R1: foreign device address is ignored
    bus_start();
    tx_byte({7'h21, 1'b0}, ack); chk(!ack, "R1 no ack foreign", ack, 0);
    tx_byte(8'h00, ack);         chk(!ack, "R1 silent byte", ack, 0);
    tx_byte(8'h02, ack);         chk(!ack, "R1 silent byte 2", ack, 0);
    tx_byte(8'hAB, ack);         chk(!ack, "R1 silent byte 3", ack, 0);
    bus_stop();
    do_read(1'b0, 16'h0, 1, "R1 pointer and data untouched");

    // R8: partial word discarded
    addr_phase(16'h000A);
    tx_byte(8'h5A, ack); chk(ack, "R8 hi byte ack", ack, 1);
    bus_stop();
    do_read(1'b0, 16'h0, 1, "R8 partial write dropped");

    // R10: START three bits into a byte
    do_write(16'h000C, 1);          // pointer now 13
    bus_start();
    tx_byte({DEV, 1'b0}, ack); chk(ack, "R10 dev ack", ack, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    tx_byte({DEV, 1'b1}, ack); chk(ack, "R10 read after abort ack", ack, 1);
    begin
      logic [7:0] hi, lo;
      rx_byte(hi, 1'b1);
      rx_byte(lo, 1'b0);
      chk({hi, lo} == exp_mem[exp_ptr], "R10 pointer kept", {hi, lo}, exp_mem[exp_ptr]);
      exp_ptr = wrap(exp_ptr);
    end
    bus_stop();

    // seeded random bursts
    for (int it = 0; it < 14; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom % 64);
      n = 1 + int'($urandom % 3);
      do_write(a, n);
      if (it % 3 == 0) begin
        exp_ptr = a % DEPTH;
        do_read(1'b1, a, n, "R6 random burst");
      end else begin
        do_read(1'b1, a, n, "R3 random burst");
        do_read(1'b0, 16'h0, 1, "R5 random current");
      end
    end

    chk(viol == 0, "R11 oe moved with scl high", viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule